// File: doc/BRIEF.md
# Register File With Write-Bus Select

A parameterised register file holding a power-of-two number of words, each of configurable width, with one write port and one read port. Each port has its own address, so one word can be read while another is written in the same cycle. The word to be stored comes from one of two write data buses, and a single select input picks which bus is used. Both addresses are decoded inside the block.

The read data output is a register. On a clock edge with read enable high, it loads the word at the read address and keeps that value while read enable stays low. If a word is read and written in the same cycle, the read returns the contents from before the write. An elaboration-time parameter turns word 0 into a constant zero: writes to it are accepted and have no effect, and reads of it always return zero. A synchronous active-high reset clears only the read data register. The storage words are not reset.

Top module: `dualsrc_regfile`

## Requirements
- R1: With `bus_sel` = 0 and `wr_en` = 1 on a rising edge, the word at `wr_addr` takes the value of `wdata_a`.
- R2: With `bus_sel` = 1 and `wr_en` = 1 on a rising edge, the word at `wr_addr` takes the value of `wdata_b`.
- R3: With `wr_en` = 0, no word changes, whatever the values of the address and the data buses.
- R4: On a rising edge with `rd_en` = 1, `rdata` takes the word at `rd_addr`. It is visible one cycle after the address is presented. Address widths are log2(WORDS).
- R5: On a rising edge with `rd_en` = 0 and `rst` = 0, `rdata` keeps its previous value.
- R6: A read and a write of the same address in the same cycle return the old contents. The new value is seen by a later read.
- R7: With `ZERO_WORD0` = 1, a read of address 0 returns all zeros, even after a write to address 0. Writes to address 0 disturb no other word.
- R8: A rising edge with `rst` = 1 sets `rdata` to zero.
- R9: A read of one address and a write of a different address in the same cycle both complete. The read returns the stored word, and the write is visible to later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the read data register |
| bus_sel | input | 1 | Write bus select: 0 picks `wdata_a`, 1 picks `wdata_b` |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| rd_addr | input | log2(WORDS) | Read address |
| wr_addr | input | log2(WORDS) | Write address |
| wdata_a | input | WIDTH | First write data bus |
| wdata_b | input | WIDTH | Second write data bus |
| rdata | output | WIDTH | Registered read data |

## Verification
Two instances, one plain and one with the zero word, receive the same stimulus. This shows how address 0 behaves in each build. Every word is written with the select input alternating while the two buses carry different values, so a wrong bus choice or a wrong address decode gives a wrong read. Further patterns each separate one behaviour: writes with the enable low, reads with the enable low while the address moves, a read and write of the same address (old data versus forwarded new data), and a read and write of different addresses.

// File: rtl/rfw_pkg.sv
package rfw_pkg;
  function automatic bit rfw_is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/rfw_bus_mux.sv
module rfw_bus_mux #(
  parameter int WIDTH = 32
) (
  input  logic             bus_sel,
  input  logic [WIDTH-1:0] wdata_a,
  input  logic [WIDTH-1:0] wdata_b,
  output logic [WIDTH-1:0] wdata
);
  always_comb begin
    if (bus_sel) wdata = wdata_b;
    else         wdata = wdata_a;
  end
endmodule

// File: rtl/rfw_wr_gate.sv
module rfw_wr_gate #(
  parameter int WORDS      = 8,
  parameter bit ZERO_WORD0 = 1'b0,
  localparam int AW        = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          mem_we
);
  generate
    if (ZERO_WORD0) begin : g_zero
      always_comb mem_we = wr_en && (wr_addr != '0);
    end else begin : g_plain
      always_comb mem_we = wr_en;
    end
  endgenerate

  assert_no_write_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !mem_we);

  generate
    if (ZERO_WORD0) begin : g_zchk
      assert_word0_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_addr == '0) |-> !mem_we);
    end
  endgenerate
endmodule

// File: rtl/rfw_array.sv
module rfw_array #(
  parameter int WORDS      = 8,
  parameter int WIDTH      = 32,
  parameter bit ZERO_WORD0 = 1'b0,
  localparam int AW        = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mem_we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];
  logic             rd_zero;

  generate
    if (ZERO_WORD0) begin : g_zero
      always_comb rd_zero = (rd_addr == '0);
    end else begin : g_plain
      always_comb rd_zero = 1'b0;
    end
  endgenerate

  // write port: inferable as a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_addr] <= wdata;
  end

  // registered read port, old data on a same-address collision
  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (rd_en)   rdata <= rd_zero ? '0 : mem[rd_addr];
  end

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (rdata == '0));
endmodule

// File: rtl/dualsrc_regfile.sv
module dualsrc_regfile #(
  parameter int WORDS      = 8,
  parameter int WIDTH      = 32,
  parameter bit ZERO_WORD0 = 1'b0,
  localparam int AW        = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wdata_a,
  input  logic [WIDTH-1:0] wdata_b,
  output logic [WIDTH-1:0] rdata
);
  import rfw_pkg::*;

  logic [WIDTH-1:0] wdata;
  logic             mem_we;

  initial begin
    assert_words_pow2_R4: assert (rfw_is_pow2(WORDS))
      else $error("WORDS must be a power of two");
  end

  rfw_bus_mux #(.WIDTH(WIDTH)) u_mux (
    .bus_sel(bus_sel), .wdata_a(wdata_a), .wdata_b(wdata_b), .wdata(wdata)
  );

  rfw_wr_gate #(.WORDS(WORDS), .ZERO_WORD0(ZERO_WORD0)) u_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .mem_we(mem_we)
  );

  rfw_array #(.WORDS(WORDS), .WIDTH(WIDTH), .ZERO_WORD0(ZERO_WORD0)) u_array (
    .clk(clk), .rst(rst), .mem_we(mem_we), .wr_addr(wr_addr), .wdata(wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata)
  );

  generate
    if (ZERO_WORD0) begin : g_zchk
      assert_zero_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == '0) |=> (rdata == '0));
    end
  endgenerate
endmodule

// File: tb/dualsrc_regfile_tb_top.sv
module dualsrc_regfile_tb_top;
  localparam int WORDS = 8;
  localparam int WIDTH = 32;
  localparam int AW    = $clog2(WORDS);

  typedef struct {
    logic [WIDTH-1:0] exp_n;
    logic [WIDTH-1:0] exp_z;
    string            tag;
  } item_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst = 1'b1, bus_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]    rd_addr = '0, wr_addr = '0;
  logic [WIDTH-1:0] wdata_a = '0, wdata_b = '0;
  logic [WIDTH-1:0] rdata_n, rdata_z;

  dualsrc_regfile #(.WORDS(WORDS), .WIDTH(WIDTH), .ZERO_WORD0(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .wr_en(wr_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wdata_a(wdata_a), .wdata_b(wdata_b),
    .rdata(rdata_n));

  dualsrc_regfile #(.WORDS(WORDS), .WIDTH(WIDTH), .ZERO_WORD0(1'b1)) dut_z_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .wr_en(wr_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wdata_a(wdata_a), .wdata_b(wdata_b),
    .rdata(rdata_z));

  item_t            sb_q[$];
  logic [WIDTH-1:0] model_n [WORDS];
  logic [WIDTH-1:0] model_z [WORDS];
  logic [WIDTH-1:0] hold_n = '0, hold_z = '0;
  int               n_tests = 0, n_fail = 0;
  bit               done = 1'b0;

  task automatic step(input logic r, input logic s, input logic we, input logic re,
                      input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                      input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                      input string tag);
    item_t it;
    @(negedge clk);
    rst = r; bus_sel = s; wr_en = we; rd_en = re;
    rd_addr = ra; wr_addr = wa; wdata_a = a; wdata_b = b;
    if (r) begin
      hold_n = '0; hold_z = '0;
    end else if (re) begin
      hold_n = model_n[ra];
      hold_z = (ra == '0) ? '0 : model_z[ra];
    end
    if (we) begin
      model_n[wa] = s ? b : a;
      if (wa != '0) model_z[wa] = s ? b : a;
    end
    it.exp_n = hold_n; it.exp_z = hold_z; it.tag = tag;
    @(posedge clk);
    #1 sb_q.push_back(it);
  endtask

  // monitor: compares one result per cycle, half a cycle after the edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_tests += 2;
        if (rdata_n !== it.exp_n) begin
          n_fail++;
          $display("FAIL %s plain: got %h expected %h", it.tag, rdata_n, it.exp_n);
        end
        if (rdata_z !== it.exp_z) begin
          n_fail++;
          $display("FAIL %s zero-word: got %h expected %h", it.tag, rdata_z, it.exp_z);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset clears the read register
    step(1, 0, 0, 0, 0, 0, 0, 0, "R8 reset");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R8 reset");
    // R1/R2: fill every word, select alternating, buses differ
    for (int i = 0; i < WORDS; i++)
      step(0, i[0], 1, 0, 0, AW'(i), 32'hA000_0000 + i, 32'hB000_0000 + i,
           i[0] ? "R2 write bus b" : "R1 write bus a");
    // R4: read every word back
    for (int i = 0; i < WORDS; i++)
      step(0, 0, 0, 1, AW'(i), 0, 0, 0, "R4 read R1 R2 R7 data");
    // R3: writes with enable low leave word 3 intact
    step(0, 0, 0, 0, 0, 3, 32'hDEAD_0003, 32'hBEEF_0003, "R3 disabled write");
    step(0, 1, 0, 0, 0, 3, 32'hDEAD_0013, 32'hBEEF_0013, "R3 disabled write");
    step(0, 0, 0, 1, 3, 0, 0, 0, "R3 word unchanged");
    // R5: read enable low holds output while address moves
    step(0, 0, 0, 0, 6, 0, 0, 0, "R5 hold");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R5 hold");
    // R6: same-address read/write returns old, then new
    step(0, 1, 1, 1, 5, 5, 32'h1111_1111, 32'h5555_AAAA, "R6 old data");
    step(0, 0, 0, 1, 5, 0, 0, 0, "R6 new data");
    // R7: write to address 0, read 0 and neighbour 1
    step(0, 0, 1, 0, 0, 0, 32'h0F0F_0F0F, 32'h7777_7777, "R7 write word0");
    step(0, 0, 0, 1, 0, 0, 0, 0, "R7 read word0");
    step(0, 0, 0, 1, 1, 0, 0, 0, "R7 neighbour intact");
    // R9: read one word while writing another
    step(0, 1, 1, 1, 2, 7, 32'h2222_2222, 32'hC0DE_0007, "R9 concurrent read");
    step(0, 0, 0, 1, 7, 0, 0, 0, "R9 concurrent write visible");
    // R8: reset mid-run, then read still works
    step(1, 0, 0, 0, 0, 0, 0, 0, "R8 reset mid-run");
    step(0, 0, 0, 0, 4, 0, 0, 0, "R8 stays cleared");
    step(0, 0, 0, 1, 4, 0, 0, 0, "R4 read after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule